// File: doc/BRIEF.md
# Piecewise-Linear Quadrature NCO

This block is a numerically controlled oscillator that needs no sine lookup memory. A 16-bit phase register is advanced once per clock. The step added each clock is a fixed free-running word plus a signed tuning word. With the tuning word at zero, the block runs at its free-running frequency. The output frequency is `(free word + tuning) / 2^16` of the clock frequency. For example, with a 50 MHz clock and a free word of 1317, a tuning word of 1317 gives roughly 2 MHz.

Each output channel folds its phase into the first quarter wave. The quarter wave is split into eight equal segments, and each segment is approximated by a straight line of the form `constant + slope × offset`. The constants and slopes are fixed least-squares fits to a sine of amplitude 127. The sign is then restored from the quadrant. The cosine channel uses the same datapath, fed with the phase advanced by a quarter turn. Both channels drive registered 8-bit signed samples, which is what a mixer or a phase detector in a digital loop consumes.

Top module: `pl_quad_nco`

## Requirements
- R1: Each clock the phase register advances by `(1317 + tune_i)` modulo 65536, where `tune_i` is 16-bit two's complement.
- R2: With `tune_i` held at 0 the phase step is exactly 1317, the free-running rate.
- R3: `sin_o` lies within 2 LSB of `round(127·sin(2π·p/65536))`, where `p` is the phase the register held before the clock edge that loaded the sample.
- R4: `cos_o` lies within 2 LSB of `round(127·cos(2π·p/65536))` for the same `p`.
- R5: Shifting the phase by 32768 negates both outputs exactly: `sin(p+32768) = −sin(p)`.
- R6: The cosine equals the sine of the phase advanced by 16384, bit for bit: `cos(p) = sin(p+16384)`.
- R7: Both outputs stay within −127..+127; the code −128 (0x80) never appears.
- R8: A sample reflects the phase held one edge earlier. A tuning change applied before edge k first alters the phase used by the sample loaded at edge k+1.
- R9: While `rst_n` is low at a clock edge, the phase and both outputs are cleared to 0. The first sample after release is taken at phase 0.
- R10: At phase 0 the outputs are sin 0 and cos +127. At 16384 the sine is +127. At 32768 the outputs are sin 0 and cos −127. At 49152 the sine is −127.
- R11: Negative tuning words reduce the step and wrap below zero, so a net step of 65531 makes the phase run backwards by 5 per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tune_i | input | 16 | Signed tuning word added to the free-running step |
| sin_o | output | 8 | Signed sine sample, registered |
| cos_o | output | 8 | Signed cosine sample, registered |

## Verification
A sample is due one clock edge after the phase register held the value that produced it. The first sample after reset release therefore shows phase 0, and a tuning change shows up in the phase of the sample two edges later.

The bench keeps its own phase model and advances it once per edge, using the tuning word that was held across that edge. It reads the outputs at the following falling edge, so the model and the registered samples stay one edge apart. The exact symmetry checks run on a sweep with a step of 64, comparing stored samples 256 and 512 steps apart.

// File: rtl/nco_pkg.sv
// nco_pkg: shared constants and the fitted segment coefficients for the
// quarter-wave line approximation. Coefficients are in units of 1/16 LSB of
// an amplitude-127 sine; each segment spans pi/16 of phase.
package nco_pkg;
    localparam int SEG_BITS  = 3;
    localparam int NSEG      = 1 << SEG_BITS;
    localparam int COEF_FRAC = 4;
    localparam int AMP_W     = 8;
    localparam int AMP_MAX   = (1 << (AMP_W - 1)) - 1;
    localparam int MAG_W     = AMP_W - 1;
    localparam int BASE_W    = 12;
    localparam int SLOPE_W   = 10;

    // Segment start value, least-squares shifted above the chord.
    function automatic logic [BASE_W-1:0] seg_base(input logic [SEG_BITS-1:0] i);
        case (i)
            3'd0:    seg_base = 12'd1;
            3'd1:    seg_base = 12'd398;
            3'd2:    seg_base = 12'd781;
            3'd3:    seg_base = 12'd1133;
            3'd4:    seg_base = 12'd1442;
            3'd5:    seg_base = 12'd1695;
            3'd6:    seg_base = 12'd1884;
            default: seg_base = 12'd1999;
        endcase
    endfunction

    // Rise across a full segment.
    function automatic logic [SLOPE_W-1:0] seg_slope(input logic [SEG_BITS-1:0] i);
        case (i)
            3'd0:    seg_slope = 10'd396;
            3'd1:    seg_slope = 10'd381;
            3'd2:    seg_slope = 10'd351;
            3'd3:    seg_slope = 10'd308;
            3'd4:    seg_slope = 10'd253;
            3'd5:    seg_slope = 10'd188;
            3'd6:    seg_slope = 10'd116;
            default: seg_slope = 10'd39;
        endcase
    endfunction
endpackage

// File: rtl/nco_phase_acc.sv
// nco_phase_acc: modulo-2^ACC_W phase register stepping by FREE_WORD plus a
// sign-extended tuning word. Assumes TUNE_W <= ACC_W.
module nco_phase_acc #(
    parameter int ACC_W     = 16,
    parameter int TUNE_W    = 16,
    parameter int FREE_WORD = 1317
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TUNE_W-1:0] tune,
    output logic [ACC_W-1:0]         phase
);
    localparam logic [ACC_W-1:0] FREE_V = ACC_W'(FREE_WORD);

    logic [ACC_W-1:0] tune_ext;
    logic [ACC_W-1:0] step;

    // Form the per-clock step, wrapping modulo 2^ACC_W.
    always_comb begin
        tune_ext = ACC_W'(tune);
        step     = FREE_V + tune_ext;
    end

    // Advance the phase; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + step;
    end
endmodule

// File: rtl/nco_fold.sv
// nco_fold: maps a full-circle phase onto the first quarter wave. Odd
// quadrants mirror the in-quadrant angle (bitwise inversion, a one-code
// phase shift); the upper half sets the negate flag.
module nco_fold
    import nco_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int OFF_W = ACC_W - 2 - SEG_BITS
) (
    input  logic [ACC_W-1:0]    phase,
    output logic [SEG_BITS-1:0] seg,
    output logic [OFF_W-1:0]    off,
    output logic                neg
);
    logic [1:0]       quad;
    logic [ACC_W-3:0] ang;
    logic [ACC_W-3:0] ang_m;

    // Split quadrant from angle and mirror where the curve falls.
    always_comb begin
        quad  = phase[ACC_W-1 -: 2];
        ang   = phase[ACC_W-3:0];
        ang_m = quad[0] ? ~ang : ang;
        seg   = ang_m[ACC_W-3 -: SEG_BITS];
        off   = ang_m[OFF_W-1:0];
        neg   = quad[1];
    end
endmodule

// File: rtl/nco_seg_eval.sv
// nco_seg_eval: evaluates base + slope*offset for the selected segment,
// rounds to whole LSB and saturates at AMP_MAX. Purely combinational.
module nco_seg_eval
    import nco_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input  logic [SEG_BITS-1:0] seg,
    input  logic [OFF_W-1:0]    off,
    output logic [MAG_W-1:0]    mag
);
    localparam int SUM_W = BASE_W + OFF_W + 2;
    localparam int SH    = OFF_W + COEF_FRAC;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] scaled;

    // Linear interpolation with round-half-up and clamp.
    always_comb begin
        sum    = (SUM_W'(seg_base(seg)) << OFF_W)
               + SUM_W'(seg_slope(seg)) * SUM_W'(off)
               + (SUM_W'(1) << (SH - 1));
        scaled = sum >> SH;
        if (scaled > SUM_W'(AMP_MAX)) mag = MAG_W'(AMP_MAX);
        else                          mag = scaled[MAG_W-1:0];
    end
endmodule

// File: rtl/nco_chan.sv
// nco_chan: one output channel. Folds its phase, evaluates the segment line,
// restores the sign and registers the signed sample. Reset clears it.
module nco_chan
    import nco_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        phase,
    output logic signed [AMP_W-1:0] sample
);
    localparam int OFF_W = ACC_W - 2 - SEG_BITS;

    logic [SEG_BITS-1:0] seg;
    logic [OFF_W-1:0]    off;
    logic                neg;
    logic [MAG_W-1:0]    mag;
    logic [AMP_W-1:0]    mag_ext;

    nco_fold #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_fold (
        .phase(phase), .seg(seg), .off(off), .neg(neg)
    );

    nco_seg_eval #(.OFF_W(OFF_W)) u_eval (
        .seg(seg), .off(off), .mag(mag)
    );

    // Zero-extend the magnitude ahead of the sign step.
    always_comb mag_ext = {1'b0, mag};

    // Register the signed sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   sample <= '0;
        else if (neg) sample <= -$signed(mag_ext);
        else          sample <= $signed(mag_ext);
    end
endmodule

// File: rtl/pl_quad_nco.sv
// pl_quad_nco: memory-free quadrature NCO. One phase register feeds two
// identical channels; the second sees the phase plus a quarter turn.
// Samples appear one clock after the phase they represent.
module pl_quad_nco
    import nco_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int TUNE_W    = 16,
    parameter int FREE_WORD = 1317
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TUNE_W-1:0] tune_i,
    output logic signed [AMP_W-1:0]  sin_o,
    output logic signed [AMP_W-1:0]  cos_o
);
    localparam int               NCH = 2;
    localparam logic [ACC_W-1:0] QTR = ACC_W'(1) << (ACC_W - 2);

    logic [ACC_W-1:0]       phase_q;
    logic signed [AMP_W-1:0] smp [NCH];

    nco_phase_acc #(.ACC_W(ACC_W), .TUNE_W(TUNE_W), .FREE_WORD(FREE_WORD)) u_acc (
        .clk(clk), .rst_n(rst_n), .tune(tune_i), .phase(phase_q)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [ACC_W-1:0] ch_phase;
        // Channel 0 is the sine, channel 1 leads by a quarter turn.
        always_comb ch_phase = phase_q + ((ch == 0) ? '0 : QTR);
        nco_chan #(.ACC_W(ACC_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .phase(ch_phase), .sample(smp[ch])
        );
    end

    assign sin_o = smp[0];
    assign cos_o = smp[1];
endmodule

// File: rtl/nco_chk.sv
// nco_chk: temporal properties of pl_quad_nco, bound onto every instance.
module nco_chk #(
    parameter int ACC_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ACC_W-1:0]       phase,
    input logic signed [7:0]      sin_o,
    input logic signed [7:0]      cos_o
);
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

    // R7
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_o != 8'sh80) && (cos_o != 8'sh80));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sin_o == 8'sd0) && (cos_o == 8'sd0) && (phase == '0));

    // R10
    zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase) == '0) |-> (sin_o == 8'sd0) && (cos_o == 8'sd127));

    // R10
    half_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase) == HALF) |-> (sin_o == 8'sd0) && (cos_o == -8'sd127));

    // R3
    sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(phase[ACC_W-1])) |-> !sin_o[7]);

    // R4
    cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(phase[ACC_W-1]) == $past(phase[ACC_W-2]))) |-> !cos_o[7]);
endmodule

bind pl_quad_nco nco_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase_q), .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/sim_pl_quad_nco.sv
`timescale 1ns/1ps
module sim_pl_quad_nco;
    localparam int FREE = 1317;
    localparam int NSW  = 1024;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] tune = 16'sd0;
    logic signed [7:0]  sin_o, cos_o;

    int checks = 0;
    int errors = 0;
    int ref_ph = 0;
    bit done = 1'b0;
    logic signed [7:0] s_arr [NSW];
    logic signed [7:0] c_arr [NSW];

    pl_quad_nco #(.FREE_WORD(FREE)) u0 (
        .clk(clk), .rst_n(rst_n), .tune_i(tune), .sin_o(sin_o), .cos_o(cos_o)
    );

    always #2.5 clk = ~clk;

    function automatic int ideal(input int ph, input bit is_cos);
        real r;
        r = 2.0 * 3.14159265358979 * ph / 65536.0;
        r = 127.0 * (is_cos ? $cos(r) : $sin(r));
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_tol(input string tag, input int ph, input int act, input int exp);
        checks++;
        if (act - exp > 2 || exp - act > 2) begin
            errors++;
            $display("FAIL %s phase %0d: got %0d expected %0d (+/-2)", tag, ph, act, exp);
        end
    endtask

    // Hold reset across two edges, check cleared outputs, release at negedge.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R9 sin in reset", int'(sin_o), 0);
        chk_eq("R9 cos in reset", int'(cos_o), 0);
        ref_ph = 0;
        rst_n = 1'b1;
    endtask

    // One edge: the sample loaded reflects the model phase before the step.
    task automatic tick(input string tag, output int ph);
        ph = ref_ph;
        ref_ph = (ref_ph + FREE + int'(tune)) & 16'hFFFF;
        @(negedge clk);
        chk_tol({tag, " R3 sin"}, ph, int'(sin_o), ideal(ph, 1'b0));
        chk_tol({tag, " R4 cos"}, ph, int'(cos_o), ideal(ph, 1'b1));
    endtask

    initial begin
        int ph;
        @(negedge clk);
        do_reset();

        // R9: first sample after release is phase 0
        tick("R9", ph);
        chk_eq("R9 first sin", int'(sin_o), 0);
        chk_eq("R9 first cos", int'(cos_o), 127);

        // R2 / R1: free-running step
        for (int i = 0; i < 300; i++) tick("R2", ph);

        // R8: tuning change mid-run; model applies it one edge later in the samples
        tune = 16'sd300;
        for (int i = 0; i < 20; i++) tick("R8", ph);
        tune = 16'sd0;
        tick("R8", ph);
        chk_eq("R8 phase after change", ph, (301 * FREE + 20 * 300 + 20 * FREE) & 16'hFFFF);

        // Reset from a running state
        do_reset();

        // R5/R6/R10: step-64 sweep over the full circle
        tune = 16'(64 - FREE);
        do_reset();
        for (int k = 0; k < NSW; k++) begin
            tick("R1", ph);
            chk_eq("R1 sweep phase", ph, k * 64);
            s_arr[k] = sin_o;
            c_arr[k] = cos_o;
        end
        for (int k = 0; k < NSW / 2; k++) begin
            chk_eq("R5 sin half-turn", int'(s_arr[k + NSW/2]), -int'(s_arr[k]));
            chk_eq("R5 cos half-turn", int'(c_arr[k + NSW/2]), -int'(c_arr[k]));
        end
        for (int k = 0; k < NSW - NSW/4; k++)
            chk_eq("R6 cos equals shifted sin", int'(c_arr[k]), int'(s_arr[k + NSW/4]));
        for (int k = 0; k < NSW; k++) begin
            chk_eq("R7 sin not -128", int'(s_arr[k] == -8'sd128), 0);
            chk_eq("R7 cos not -128", int'(c_arr[k] == -8'sd128), 0);
        end
        chk_eq("R10 sin at 0", int'(s_arr[0]), 0);
        chk_eq("R10 cos at 0", int'(c_arr[0]), 127);
        chk_eq("R10 sin at 16384", int'(s_arr[256]), 127);
        chk_eq("R10 sin at 32768", int'(s_arr[512]), 0);
        chk_eq("R10 cos at 32768", int'(c_arr[512]), -127);
        chk_eq("R10 sin at 49152", int'(s_arr[768]), -127);

        // R11: net step of -5 (runs backwards)
        tune = 16'(-FREE - 5);
        do_reset();
        for (int i = 0; i < 300; i++) tick("R11", ph);
        chk_eq("R11 backward phase", ph, (65536 - 299 * 5) & 16'hFFFF);

        // R11: large positive tuning wraps the sum
        tune = 16'sd32767;
        do_reset();
        for (int i = 0; i < 300; i++) tick("R11", ph);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule